// File: doc/BRIEF.md
# Synchronous Burst NOR Read Sequencer

This block turns single host read requests into synchronous burst reads on a NOR flash with a 16-bit data bus. The host presents an address, a transfer size (16 or 32 bit) and a chip-select number. The sequencer drives the memory clock, the chip selects, output enable, an active-low address-valid strobe and the address. It samples the data bus and a wait input from the memory, then returns the read word to the host with a one-cycle valid pulse.

Each of the four chip selects has its own settings, supplied as inputs: a data latency count, a wait polarity and a wait timing mode. The latency count excludes the address-valid cycle. The wait input is looked at only once the latency has run out. A 32-bit request becomes a two-beat burst, and the two halfwords are assembled into one word.

Top module: `nor_burst_seq`

## Requirements
- R1: After reset all chip selects (`memCsN`), `memOeN` and `memAdvN` are high, `memClk` and `rspValid` are low, and `reqReady` is high.
- R2: A burst opens with `memAdvN` low for exactly one memory clock period, which is two system clocks and starts with `memClk` low. `memAddr` carries the request address during that period. Only the selected `memCsN` bit (bit index = `reqCs`) is low.
- R3: While a burst is in progress, `memClk` toggles on every system clock, so it runs at half the system clock. It starts low in the cycle after acceptance. It is low whenever the sequencer is idle.
- R4: Counting rising `memClk` edges after the address edge, the first wait evaluation happens on edge number DATLAT+2. DATLAT is bits `[4*cs+3:4*cs]` of `cfgLatency`. The level of `memWait` on earlier edges has no effect.
- R5: `cfgWaitPol[cs]`=0 means `memWait` low is active. `cfgWaitPol[cs]`=1 means `memWait` high is active.
- R6: With `cfgWaitCfg[cs]`=1, data is captured on the same rising edge where wait is first seen inactive.
- R7: With `cfgWaitCfg[cs]`=0, data is captured on the rising edge after the one where wait is seen inactive. The wait level on that capture edge is not considered.
- R8: While wait is active, `memClk` keeps toggling, chip select and `memOeN` stay low, and the data bus is not captured.
- R9: A 16-bit request is a burst of one beat. `rspData` returns the beat in bits [15:0], with zeros in bits [31:16].
- R10: A 32-bit request is a burst of two beats. The first beat fills `rspData[15:0]` and the second fills `rspData[31:16]`. There is a single `rspValid` pulse, after the second beat.
- R11: In the system clock that follows the rising edge capturing the last beat, chip select and `memOeN` are deasserted and `rspValid` is high for exactly one cycle.
- R12: A request is accepted only when `reqReady` is high, and `reqReady` is low while a burst is in progress. Requests presented during a burst are ignored, and `memAddr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host read request |
| reqReady | output | 1 | Sequencer idle, request can be accepted |
| reqAddr | input | 24 | Read address |
| reqSize32 | input | 1 | 1 = 32-bit read, 0 = 16-bit read |
| reqCs | input | 2 | Chip select number |
| cfgLatency | input | 16 | Four 4-bit latency values, chip select n at bits [4n+3:4n] |
| cfgWaitPol | input | 4 | Per chip select wait polarity |
| cfgWaitCfg | input | 4 | Per chip select wait timing mode |
| memClk | output | 1 | Memory clock |
| memCsN | output | 4 | Active-low chip selects |
| memAdvN | output | 1 | Active-low address-valid strobe |
| memOeN | output | 1 | Active-low output enable |
| memAddr | output | 24 | Memory address |
| memData | input | 16 | Memory read data |
| memWait | input | 1 | Memory wait input |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | 32 | Read data |

## Verification
On a single rising memory edge, wait evaluation and beat capture coincide. In the delayed-valid mode, an armed capture edge can also coincide with a fresh wait assertion. The bench provokes this by driving wait active on the very edge where the armed capture is due. The reference model expects the beat to be taken anyway.

The bench also drives wait at its active level on every latency edge, so that a latency miscount shows up as an early or late capture. The reference model computes the exact capture edges from the requirements and compares every output on every system clock.

// File: rtl/nor_burst_pkg.sv
package nor_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LAT,
    ST_DATA
  } seqState_t;

  typedef struct packed {
    logic loadReq;
    logic capLow;
    logic capHigh;
    logic finish;
  } ctlStrobe_t;

endpackage

// File: rtl/nor_burst_ctrl.sv
module nor_burst_ctrl
  import nor_burst_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int LAT_W  = 4,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqSize32,
  input  logic [CS_W-1:0]         reqCs,
  input  logic [NUM_CS*LAT_W-1:0] cfgLatency,
  input  logic [NUM_CS-1:0]       cfgWaitPol,
  input  logic [NUM_CS-1:0]       cfgWaitCfg,
  input  logic                    memWait,
  output logic                    reqReady,
  output logic                    memClk,
  output logic [NUM_CS-1:0]       memCsN,
  output logic                    memAdvN,
  output logic                    memOeN,
  output ctlStrobe_t              strobe
);

  seqState_t        state;
  logic             phase;
  logic [LAT_W-1:0] latCnt;
  logic [LAT_W-1:0] latQ;
  logic [LAT_W-1:0] latSel;
  logic [CS_W-1:0]  csQ;
  logic             size32Q;
  logic             polQ;
  logic             timingQ;
  logic             beatHi;
  logic             armed;

  logic memEdge;
  logic waitActive;
  logic beatNow;
  logic lastBeat;
  logic accept;

  // pick the latency of the requested chip select
  always_comb begin
    latSel = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (reqCs == CS_W'(i)) latSel = cfgLatency[i*LAT_W +: LAT_W];
    end
  end

  assign accept     = reqValid && (state == ST_IDLE);
  assign memEdge    = (state != ST_IDLE) && !phase;
  assign waitActive = polQ ? memWait : !memWait;
  assign beatNow    = (state == ST_DATA) && memEdge && (timingQ ? !waitActive : armed);
  assign lastBeat   = beatNow && (beatHi || !size32Q);

  always_comb begin
    strobe         = '0;
    strobe.loadReq = accept;
    strobe.capLow  = beatNow && !beatHi;
    strobe.capHigh = beatNow && beatHi;
    strobe.finish  = lastBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      latCnt  <= '0;
      latQ    <= '0;
      csQ     <= '0;
      size32Q <= 1'b0;
      polQ    <= 1'b0;
      timingQ <= 1'b0;
      beatHi  <= 1'b0;
      armed   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase <= 1'b0;
          if (accept) begin
            state   <= ST_ADDR;
            latQ    <= latSel;
            csQ     <= reqCs;
            size32Q <= reqSize32;
            polQ    <= cfgWaitPol[reqCs];
            timingQ <= cfgWaitCfg[reqCs];
            beatHi  <= 1'b0;
            armed   <= 1'b0;
          end
        end
        ST_ADDR: begin
          phase <= !phase;
          if (phase) begin
            state  <= ST_LAT;
            latCnt <= latQ;
          end
        end
        ST_LAT: begin
          phase <= !phase;
          if (memEdge) begin
            if (latCnt == '0) state <= ST_DATA;
            else              latCnt <= latCnt - 1'b1;
          end
        end
        ST_DATA: begin
          if (lastBeat) begin
            state <= ST_IDLE;
            phase <= 1'b0;
          end else begin
            phase <= !phase;
            if (beatNow) begin
              beatHi <= 1'b1;
              armed  <= 1'b0;
            end else if (memEdge && !timingQ && !waitActive) begin
              armed <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign memClk   = phase;
  assign memAdvN  = (state != ST_ADDR);
  assign memOeN   = !((state == ST_LAT) || (state == ST_DATA));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csDecode
    assign memCsN[g] = !((state != ST_IDLE) && (csQ == CS_W'(g)));
  end

  // R2: address-valid low for two system clocks, then released
  p_adv_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memAdvN) |=> !memAdvN);
  p_adv_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memAdvN && $past(!memAdvN)) |=> memAdvN);
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));
  // R3: clock parked low whenever no chip select is active
  p_idle_clk_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (&memCsN) |-> !memClk);
  // R8: chip select and output enable held through data phase until the last beat
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DATA) && !lastBeat) |=> (!(&memCsN) && !memOeN));
  // R12: never ready while a chip select is asserted
  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(&memCsN) |-> !reqReady);

endmodule

// File: rtl/nor_burst_dpath.sv
module nor_burst_dpath
  import nor_burst_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [HALF_W-1:0]   memData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                rspValid,
  output logic [2*HALF_W-1:0] rspData
);

  logic [HALF_W-1:0] lowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      lowQ     <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.finish;
      if (strobe.loadReq) memAddr <= reqAddr;
      if (strobe.capLow)  lowQ    <= memData;
      if (strobe.finish) begin
        if (strobe.capHigh) rspData <= {memData, lowQ};
        else                rspData <= {{HALF_W{1'b0}}, memData};
      end
    end
  end

  // R11: response valid is a single-cycle pulse
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R10: the high halfword is never captured at the same time as a load
  p_load_vs_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadReq |-> !(strobe.capLow || strobe.capHigh));

endmodule

// File: rtl/nor_burst_seq.sv
module nor_burst_seq
  import nor_burst_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int LAT_W  = 4,
  parameter int ADDR_W = 24,
  parameter int HALF_W = 16,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    reqSize32,
  input  logic [CS_W-1:0]         reqCs,
  input  logic [NUM_CS*LAT_W-1:0] cfgLatency,
  input  logic [NUM_CS-1:0]       cfgWaitPol,
  input  logic [NUM_CS-1:0]       cfgWaitCfg,
  output logic                    memClk,
  output logic [NUM_CS-1:0]       memCsN,
  output logic                    memAdvN,
  output logic                    memOeN,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic [HALF_W-1:0]       memData,
  input  logic                    memWait,
  output logic                    rspValid,
  output logic [2*HALF_W-1:0]     rspData
);

  ctlStrobe_t strobe;

  nor_burst_ctrl #(.NUM_CS(NUM_CS), .LAT_W(LAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSize32(reqSize32),
    .reqCs(reqCs), .cfgLatency(cfgLatency), .cfgWaitPol(cfgWaitPol),
    .cfgWaitCfg(cfgWaitCfg), .memWait(memWait), .reqReady(reqReady),
    .memClk(memClk), .memCsN(memCsN), .memAdvN(memAdvN), .memOeN(memOeN),
    .strobe(strobe)
  );

  nor_burst_dpath #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .memData(memData), .memAddr(memAddr), .rspValid(rspValid), .rspData(rspData)
  );

  // R12: address held for the whole burst
  p_addr_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(memAddr));
  // R11: response coincides with chip select released
  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((&memCsN) && memOeN && reqReady));

endmodule

// File: tb/nor_burst_seq_bench.sv
module nor_burst_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic        reqSize32 = 1'b0;
  logic [1:0]  reqCs = '0;
  logic [15:0] cfgLatency = {4'd5, 4'd1, 4'd3, 4'd0};
  logic [3:0]  cfgWaitPol = 4'b1010;
  logic [3:0]  cfgWaitCfg = 4'b0011;
  logic        memClk;
  logic [3:0]  memCsN;
  logic        memAdvN;
  logic        memOeN;
  logic [23:0] memAddr;
  logic [15:0] memData = '0;
  logic        memWait = 1'b0;
  logic        rspValid;
  logic [31:0] rspData;

  int testsRun = 0;
  int testsFailed = 0;
  int burstNo = 0;
  bit summaryDone = 0;

  always #5 clk = !clk;

  nor_burst_seq u_nor_burst_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize32(reqSize32), .reqCs(reqCs),
    .cfgLatency(cfgLatency), .cfgWaitPol(cfgWaitPol), .cfgWaitCfg(cfgWaitCfg),
    .memClk(memClk), .memCsN(memCsN), .memAdvN(memAdvN), .memOeN(memOeN),
    .memAddr(memAddr), .memData(memData), .memWait(memWait),
    .rspValid(rspValid), .rspData(rspData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s burst %0d t=%0t actual=%h expected=%h", tag, burstNo, $time, act, exp);
    end
  endtask

  function automatic logic [15:0] dataAt(input int t, input int n);
    return 16'(32'h3C00 + t * 37 + n * 1000);
  endfunction

  // reference model: one host read, outputs compared on every system clock
  task automatic runRead(input logic [23:0] a, input bit s32, input int cs, input logic [15:0] scr);
    int lat = int'(cfgLatency[cs*4 +: 4]);
    bit pol = cfgWaitPol[cs];
    bit wc = cfgWaitCfg[cs];
    int e = 0;
    int beats = 0;
    bit armed = 0;
    int tDone = 0;
    logic [31:0] expData = '0;
    logic [3:0] csExp = ~(4'b0001 << cs);
    while (tDone == 0 && e < 64) begin
      int te = 3 + 2 * (lat + 1 + e);
      bit act = (e < 16) ? scr[e] : 1'b0;
      bit cap = 0;
      if (wc) cap = !act;
      else if (armed) begin cap = 1; armed = 0; end
      else if (!act) armed = 1;
      if (cap) begin
        if (beats == 0) expData[15:0] = dataAt(te, burstNo);
        else            expData[31:16] = dataAt(te, burstNo);
        beats++;
        if (beats == (s32 ? 2 : 1)) tDone = te;
      end
      e++;
    end
    @(negedge clk);
    chk(reqReady == 1'b1, "R12 ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqAddr = a; reqSize32 = s32; reqCs = 2'(cs);
    for (int t = 0; t <= tDone + 1; t++) begin
      @(posedge clk);
      @(negedge clk);
      if (t < tDone) begin
        chk(memCsN == csExp, "R2 chip select", 32'(memCsN), 32'(csExp));
        chk(memAdvN == (t > 1), "R2 address valid", 32'(memAdvN), 32'(t > 1));
        chk(memAddr == a, "R12 address held", 32'(memAddr), 32'(a));
        chk(memClk == 1'(t % 2), "R3 memory clock", 32'(memClk), 32'(t % 2));
        chk(memOeN == (t <= 1), "R8 output enable", 32'(memOeN), 32'(t <= 1));
        chk(reqReady == 1'b0, "R12 busy", 32'(reqReady), 32'd0);
        chk(rspValid == 1'b0, "R4 R6 R7 early capture", 32'(rspValid), 32'd0);
      end else if (t == tDone) begin
        chk(&memCsN && memOeN && memAdvN, "R11 release", {memCsN, memOeN, memAdvN}, 32'h3f);
        chk(memClk == 1'b0, "R3 idle clock", 32'(memClk), 32'd0);
        chk(rspValid == 1'b1, "R11 response pulse", 32'(rspValid), 32'd1);
        chk(rspData == expData, s32 ? "R10 assembled word" : "R9 single halfword", rspData, expData);
        chk(reqReady == 1'b1, "R12 ready after", 32'(reqReady), 32'd1);
      end else begin
        chk(rspValid == 1'b0, "R11 single pulse", 32'(rspValid), 32'd0);
      end
      // host keeps asking with another address while busy (R12)
      reqValid = (t < tDone - 1);
      reqAddr = ~a;
      // memory side for the next rising memory edge
      begin
        int tn = t + 1;
        int firstEval = 3 + 2 * (lat + 1);
        if ((tn % 2 == 1) && tn >= firstEval) begin
          int ei = (tn - firstEval) / 2;
          bit act = (ei < 16) ? scr[ei] : 1'b0;
          memWait = act ? pol : !pol;   // R5 polarity
        end else begin
          memWait = pol;                // active level during latency, must be ignored (R4)
        end
        memData = dataAt(tn, burstNo);
      end
    end
    reqValid = 1'b0;
    burstNo++;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    end
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(&memCsN && memOeN && memAdvN, "R1 reset strobes", {memCsN, memOeN, memAdvN}, 32'h3f);
    chk(!memClk && !rspValid && reqReady, "R1 reset clock/valid/ready",
        {memClk, rspValid, reqReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    chk(&memCsN && reqReady, "R1 after release", {memCsN, reqReady}, 32'h1f);
    // R9 R6: 16-bit, zero latency, immediate valid, no wait
    runRead(24'h000100, 1'b0, 0, 16'h0000);
    // R10 R6 R5: 32-bit, latency 3, wait active high, waits between beats
    runRead(24'h012345, 1'b1, 1, 16'b0000_0000_0000_0101);
    // R7 R8 R5: 32-bit, delayed valid, active-low wait, wait asserted on the armed capture edge
    runRead(24'h0ABCDE, 1'b1, 2, 16'b0000_0000_0001_1101);
    // R7 R4: 16-bit, long latency, delayed valid, no wait
    runRead(24'h0F0F0F, 1'b0, 3, 16'h0000);
    // R4 R6: cs0 32-bit with a long wait run
    runRead(24'h7FFFFE, 1'b1, 0, 16'b0000_0000_0011_1110);
    // R7: delayed valid with wait toggling every edge
    runRead(24'h135790, 1'b1, 2, 16'b0101_0101_0101_0101);
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    end
    $finish;
  end

endmodule